// File: doc/BRIEF.md
# Master-Mode Serial Peripheral Port with Status Flags

This block is a byte-wide serial port that always acts as the clock master of a four-wire SPI link. Software reaches it through a small register interface with four addresses: a data window, a status word, a control word and a clock divider. A byte written to the data window waits in a one-entry holding buffer. It moves into the shift register as soon as the shifter is idle, so a second byte can be queued while the first one is on the wire. Every frame shifts eight bits out on `mosi` and, over the same clock edges, eight bits in from `miso`. The received byte lands in a one-entry receive buffer when the last bit completes.

Three flags summarise the state of the port: buffer-empty, frame-done and receive-full. Each flag has an enable bit, and it drives an interrupt line only while that enable bit and the chip-wide interrupt enable input are both high. Polarity, phase and bit order are captured when a frame starts. The serial clock toggles every `divider+1` system clocks, so one full serial clock period lasts `2*(divider+1)` system clocks.

Top module: `spi_master_port`

## Requirements
- R1: After reset the status word (address 1) reads 0x01: buffer-empty (bit 0) is 1, frame-done (bit 1) is 0 and receive-full (bit 2) is 0. The control word (address 2) reads 0, `sclk` is low and all three interrupt lines are low.
- R2: Control bit 2 selects the bit order on the wire: 1 sends bit 0 of the byte first, 0 sends bit 7 first. Received bits are assembled in the same order.
- R3: Control bit 0 (polarity) sets the idle level of `sclk`. Control bit 1 (phase) selects sampling on the leading edge (0) or the trailing edge (1) of each clock pulse, with `mosi` changing on the other edge. All four combinations move a full byte in each direction.
- R4: Consecutive `sclk` edges of a frame are `divider+1` system clocks apart, where the divider is the value written to address 3. The first and last of the 16 edges of a frame are therefore `15*(divider+1)` clocks apart.
- R5: A write to address 0 is taken into the holding buffer only while the transmit enable (control bit 4) is 1 and buffer-empty is 1. The buffered byte moves into the idle shifter one clock later, and buffer-empty returns to 1 at that moment. With transmit disabled, the write changes no flag and produces no `sclk` edge.
- R6: At the end of a frame with the receive enable (control bit 3) at 1, the received byte is stored and receive-full is set. A read of address 0 returns that byte and clears receive-full.
- R7: While the receive enable is 0, the receive buffer is flushed: receive-full reads 0 one clock later, address 0 reads 0, and finished frames store nothing.
- R8: Frame-done is set when a frame finishes and no byte is waiting in the holding buffer. A frame that finishes while a second byte is queued leaves it at 0.
- R9: Frame-done is cleared by writing a 1 to bit 1 of address 1, or by a one-clock pulse on `done_ack`. Writing 0 to that bit leaves it unchanged.
- R10: Each interrupt line (`irq_rx`, `irq_done`, `irq_empty`) is high exactly when its flag is 1, its enable (control bits 5, 6 and 7 respectively) is 1, and `gie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive buffer at address 0) |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register (combinational) |
| gie | input | 1 | Global interrupt enable |
| done_ack | input | 1 | Interrupt service pulse that clears frame-done |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_done | output | 1 | Frame-done interrupt request |
| irq_empty | output | 1 | Buffer-empty interrupt request |

## Verification
The bench plays the slave. It sweeps every polarity, phase and bit order at several divider values, checks the byte seen on `mosi` and the byte returned from `miso`, and measures the edge spacing. A port that swapped sampling and shifting edges would misplace the first or the last bit. A port that reversed the order on only one side would fail the LSB-first runs in just one direction. A queued second byte is used to show that frame-done stays low until the holding buffer drains; a port that set the flag per frame would raise it early. The bench also covers the flush on receive disable, ignored writes with the transmitter off, both ways of clearing frame-done, and the interrupt gating by `gie`.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_DIV  = 2'd3
    } reg_sel_e;

    localparam int unsigned STAT_EMPTY = 0;
    localparam int unsigned STAT_DONE  = 1;
    localparam int unsigned STAT_RX    = 2;

    typedef struct packed {
        logic ie_empty;
        logic ie_done;
        logic ie_rx;
        logic tx_en;
        logic rx_en;
        logic lsb_first;
        logic cpha;
        logic cpol;
    } ctrl_t;

endpackage

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == div) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);

    localparam int unsigned EDGES = 2 * DATA_W;
    localparam int unsigned EW    = $clog2(EDGES);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [EW-1:0]     edge_idx;
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-1:0] rx_sr;
        logic              f_cpol;
        logic              f_cpha;
        logic              f_lsb;
    } sh_state_t;

    sh_state_t st_d, st_q;

    function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start && !st_q.busy) begin
            st_d.busy     = 1'b1;
            st_d.phase    = 1'b0;
            st_d.edge_idx = '0;
            st_d.tx_sr    = lsb_first ? flip(start_data) : start_data;
            st_d.rx_sr    = '0;
            st_d.f_cpol   = cpol;
            st_d.f_cpha   = cpha;
            st_d.f_lsb    = lsb_first;
        end else if (st_q.busy && tick) begin
            st_d.phase    = ~st_q.phase;
            st_d.edge_idx = st_q.edge_idx + 1'b1;
            if (st_q.edge_idx[0] == st_q.f_cpha) begin
                st_d.rx_sr = {st_q.rx_sr[DATA_W-2:0], miso};
            end else if (st_q.edge_idx != '0) begin
                st_d.tx_sr = {st_q.tx_sr[DATA_W-2:0], 1'b0};
            end
            if (st_q.edge_idx == EW'(EDGES - 1)) begin
                st_d.busy  = 1'b0;
                st_d.phase = 1'b0;
                done       = 1'b1;
            end
        end
    end

    assign rx_word = st_q.f_lsb ? flip(st_d.rx_sr) : st_d.rx_sr;
    assign busy    = st_q.busy;
    assign sclk    = st_q.busy ? (st_q.f_cpol ^ st_q.phase) : cpol;
    assign mosi    = st_q.tx_sr[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie,
    input  logic              done_ack,
    input  logic              busy,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_word,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div,
    output logic              start,
    output logic [DATA_W-1:0] start_data,
    output logic              stat_empty,
    output logic              stat_done,
    output logic              stat_rx,
    output logic              irq_rx,
    output logic              irq_done,
    output logic              irq_empty
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] tx_buf;
        logic              buf_full;
        logic              tx_done;
        logic [DATA_W-1:0] rx_buf;
        logic              rx_full;
    } reg_state_t;

    reg_state_t st_d, st_q;
    reg_sel_e   sel;
    logic       wr_data, wr_stat, wr_ctrl, wr_div, rd_data;
    logic [2:0] stat_bits;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_data = bus_wr && (sel == SEL_DATA);
    assign wr_stat = bus_wr && (sel == SEL_STAT);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign wr_div  = bus_wr && (sel == SEL_DIV);
    assign rd_data = bus_rd && (sel == SEL_DATA);

    always_comb begin
        st_d  = st_q;
        start = st_q.ctrl.tx_en && st_q.buf_full && !busy;

        if (start) st_d.buf_full = 1'b0;
        if (wr_data && st_q.ctrl.tx_en && !st_q.buf_full) begin
            st_d.tx_buf   = bus_wdata;
            st_d.buf_full = 1'b1;
        end

        if (wr_ctrl) st_d.ctrl = ctrl_t'(bus_wdata[7:0]);
        if (wr_div)  st_d.div  = bus_wdata[DIV_W-1:0];

        if ((wr_stat && bus_wdata[STAT_DONE]) || done_ack) st_d.tx_done = 1'b0;
        if (frame_done && !st_d.buf_full)                  st_d.tx_done = 1'b1;

        if (rd_data) st_d.rx_full = 1'b0;
        if (frame_done && st_q.ctrl.rx_en) begin
            st_d.rx_buf  = rx_word;
            st_d.rx_full = 1'b1;
        end
        if (!st_q.ctrl.rx_en) begin
            st_d.rx_buf  = '0;
            st_d.rx_full = 1'b0;
        end
    end

    assign stat_empty = !st_q.buf_full;
    assign stat_done  = st_q.tx_done;
    assign stat_rx    = st_q.rx_full;
    assign stat_bits  = {stat_rx, stat_done, stat_empty};

    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = st_q.rx_buf;
            SEL_STAT: bus_rdata = DATA_W'(stat_bits);
            SEL_CTRL: bus_rdata = DATA_W'(st_q.ctrl);
            default:  bus_rdata = DATA_W'(st_q.div);
        endcase
    end

    assign ctrl       = st_q.ctrl;
    assign div        = st_q.div;
    assign start_data = st_q.tx_buf;

    assign irq_rx    = gie && st_q.ctrl.ie_rx    && stat_rx;
    assign irq_done  = gie && st_q.ctrl.ie_done  && stat_done;
    assign irq_empty = gie && st_q.ctrl.ie_empty && stat_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_master_port.sv
module spi_master_port
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie,
    input  logic              done_ack,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq_rx,
    output logic              irq_done,
    output logic              irq_empty
);

    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div_val;
    logic              start, busy, tick, frame_done;
    logic [DATA_W-1:0] start_data, rx_word;
    logic              stat_empty, stat_done, stat_rx;
    logic              ctrl_rx_en, ctrl_tx_en;

    assign ctrl_rx_en = ctrl.rx_en;
    assign ctrl_tx_en = ctrl.tx_en;

    spi_port_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .gie        (gie),
        .done_ack   (done_ack),
        .busy       (busy),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .ctrl       (ctrl),
        .div        (div_val),
        .start      (start),
        .start_data (start_data),
        .stat_empty (stat_empty),
        .stat_done  (stat_done),
        .stat_rx    (stat_rx),
        .irq_rx     (irq_rx),
        .irq_done   (irq_done),
        .irq_empty  (irq_empty)
    );

    spi_port_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div_val),
        .tick  (tick)
    );

    spi_port_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_data (start_data),
        .cpol       (ctrl.cpol),
        .cpha       (ctrl.cpha),
        .lsb_first  (ctrl.lsb_first),
        .tick       (tick),
        .miso       (miso),
        .busy       (busy),
        .sclk       (sclk),
        .mosi       (mosi),
        .done       (frame_done),
        .rx_word    (rx_word)
    );

endmodule

// File: rtl/spi_master_port_checker.sv
module spi_master_port_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              done_ack,
    input logic              busy,
    input logic              buf_empty,
    input logic              tx_done,
    input logic              rx_full,
    input logic              rx_en,
    input logic              tx_en
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (buf_empty && !tx_done && !rx_full));

    p_load_from_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!buf_empty && tx_en));

    p_accept_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(bus_wr && bus_addr == 2'd0 && tx_en));

    p_rx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_full);

    p_done_when_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (buf_empty && $past(busy) && !busy));

    p_done_clear_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done) |-> $past(done_ack || (bus_wr && bus_addr == 2'd1 && bus_wdata[1])));

endmodule

bind spi_master_port spi_master_port_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done_ack  (done_ack),
    .busy      (busy),
    .buf_empty (stat_empty),
    .tx_done   (stat_done),
    .rx_full   (stat_rx),
    .rx_en     (ctrl_rx_en),
    .tx_en     (ctrl_tx_en)
);

// File: tb/spi_master_port_bench.sv
`timescale 1ns/1ps
module spi_master_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0, done_ack = 1'b0;
    logic       sclk, mosi, miso;
    logic       irq_rx, irq_done, irq_empty;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // slave model state
    logic       mon_on = 1'b0;
    logic       prev_sclk = 1'b0;
    int         ecnt = 0;
    int         first_e = 0, last_e = 0;
    logic       m_cpha = 1'b0, m_lsb = 1'b0;
    logic [7:0] sbyte = 8'd0;
    logic [2:0] sidx = 3'd0;
    logic [7:0] got0 = 8'd0, got1 = 8'd0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign miso = sbyte[m_lsb ? sidx : 3'd7 - sidx];

    spi_master_port u_spi_master_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gie(gie), .done_ack(done_ack), .sclk(sclk), .mosi(mosi), .miso(miso),
        .irq_rx(irq_rx), .irq_done(irq_done), .irq_empty(irq_empty)
    );

    always @(negedge clk) begin
        if (mon_on && sclk !== prev_sclk) begin
            int e, fr, pos;
            e  = ecnt % 16;
            fr = ecnt / 16;
            if (ecnt == 0) first_e = cyc;
            last_e = cyc;
            if ((e % 2) == int'(m_cpha)) begin
                pos = m_lsb ? e / 2 : 7 - e / 2;
                if (fr == 0) got0[pos] = mosi;
                else if (fr == 1) got1[pos] = mosi;
            end else if (!m_cpha) begin
                sidx = 3'((e + 1) / 2);
            end else begin
                sidx = 3'(e / 2);
            end
            ecnt = ecnt + 1;
        end
        prev_sclk = sclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arm(input logic cpha, input logic lsb, input logic [7:0] sb);
        @(posedge clk);
        m_cpha = cpha; m_lsb = lsb; sbyte = sb; sidx = 3'd0;
        ecnt = 0; got0 = 8'd0; got1 = 8'd0; mon_on = 1'b1;
    endtask

    task automatic wait_edges(input int n, input int div);
        int guard;
        guard = 0;
        while (ecnt < n && guard < 64 * (div + 1)) begin
            @(posedge clk);
            guard++;
        end
        repeat (div + 4) @(posedge clk);
    endtask

    task automatic frame(input logic cpol, input logic cpha, input logic lsb,
                         input int div, input logic [7:0] mb, input logic [7:0] sb);
        logic [7:0] v;
        wr(2'd3, 8'(div));
        wr(2'd2, {3'b000, 1'b1, 1'b1, lsb, cpha, cpol});
        arm(cpha, lsb, sb);
        wr(2'd0, mb);
        wait_edges(16, div);
        mon_on = 1'b0;
        check(lsb ? "R2 mosi byte" : "R3 mosi byte", {24'd0, got0}, {24'd0, mb});
        check("R4 edge span", last_e - first_e, 15 * (div + 1));
        check("R3 idle level", {31'd0, sclk}, {31'd0, cpol});
        rd(2'd1, v);
        check("R6 R8 status after frame", {24'd0, v}, 32'h07);
        rd(2'd0, v);
        check(lsb ? "R2 miso byte" : "R6 miso byte", {24'd0, v}, {24'd0, sb});
        rd(2'd1, v);
        check("R6 read pops", {24'd0, v}, 32'h03);
        wr(2'd1, 8'h02);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int idx;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); check("R1 status", {24'd0, v}, 32'h01);
        rd(2'd2, v); check("R1 control", {24'd0, v}, 32'h00);
        check("R1 sclk", {31'd0, sclk}, 32'd0);
        check("R1 irqs", {29'd0, irq_rx, irq_done, irq_empty}, 32'd0);

        // R10 gating of buffer-empty interrupt
        wr(2'd2, 8'h80);
        check("R10 gie low", {31'd0, irq_empty}, 32'd0);
        gie = 1'b1; #1;
        check("R10 gie high", {31'd0, irq_empty}, 32'd1);
        gie = 1'b0;

        // R5 transmit disabled: write ignored, no clock activity
        wr(2'd2, 8'h08);
        arm(1'b0, 1'b0, 8'h00);
        wr(2'd0, 8'h55);
        rd(2'd1, v); check("R5 write ignored", {24'd0, v}, 32'h01);
        repeat (40) @(posedge clk);
        check("R5 no edges", ecnt, 0);
        mon_on = 1'b0;

        // R2 R3 R4 R6 sweep over modes, order and divider
        idx = 0;
        for (int d = 0; d < 3; d++) begin
            for (int m = 0; m < 8; m++) begin
                frame(m[0], m[1], m[2], (d == 2) ? 3 : d,
                      8'h5A ^ 8'(idx * 37), 8'hC3 + 8'(idx * 19));
                idx++;
            end
        end

        // R5 R8 double buffering with two queued bytes
        wr(2'd3, 8'd1);
        wr(2'd2, 8'h18);
        arm(1'b0, 1'b0, 8'h96);
        wr(2'd0, 8'hE1);
        rd(2'd1, v); check("R5 empty after load", {30'd0, v[1:0]}, 32'h1);
        wr(2'd0, 8'h3B);
        rd(2'd1, v); check("R5 buffer held", {31'd0, v[0]}, 32'd0);
        while (ecnt < 18) @(posedge clk);
        rd(2'd1, v); check("R8 no done while queued", {31'd0, v[1]}, 32'd0);
        wait_edges(32, 1);
        mon_on = 1'b0;
        rd(2'd1, v); check("R8 done after drain", {31'd0, v[1]}, 32'd1);
        check("R5 first byte", {24'd0, got0}, 32'hE1);
        check("R5 second byte", {24'd0, got1}, 32'h3B);

        // R9 clear paths; R10 done/rx interrupts
        wr(2'd2, 8'h78);
        gie = 1'b1; #1;
        check("R10 irq_done", {31'd0, irq_done}, 32'd1);
        check("R10 irq_rx", {31'd0, irq_rx}, 32'd1);
        gie = 1'b0; #1;
        check("R10 gated off", {30'd0, irq_done, irq_rx}, 32'd0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R9 zero write keeps", {31'd0, v[1]}, 32'd1);
        @(negedge clk) done_ack = 1'b1;
        @(negedge clk) done_ack = 1'b0;
        rd(2'd1, v); check("R9 ack clears", {31'd0, v[1]}, 32'd0);

        // R7 receive disable flushes the buffer
        check("R7 full before", {31'd0, 1'b1}, {31'd0, v[2]});
        wr(2'd2, 8'h10);
        rd(2'd1, v); check("R7 flag flushed", {31'd0, v[2]}, 32'd0);
        rd(2'd0, v); check("R7 data flushed", {24'd0, v}, 32'd0);
        arm(1'b0, 1'b0, 8'h77);
        wr(2'd0, 8'h12);
        wait_edges(16, 1);
        mon_on = 1'b0;
        rd(2'd1, v); check("R7 no store", {24'd0, v}, 32'h03);
        wr(2'd1, 8'h02);
        rd(2'd1, v); check("R9 write-one clears", {31'd0, v[1]}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule